// File: doc/BRIEF.md
# Byte-Stepped Two-Wire Bus Master

This block is a controller that drives a two-wire (I2C) bus as the only master. A host gives it one command at a time: generate a start condition, generate a stop condition, or move one byte. After a start condition the first byte moved is the address byte. Its least significant bit selects the direction for the bytes that follow: 0 means the master writes and 1 means the master reads. The block drives both bus lines in open-drain fashion. An output-enable high pulls the line low, and the block reads the real line level back through its inputs.

After every bus event the block stops with SCL held low, raises `flag` and puts an event code on `status`. It then waits for the next host command, and that command clears the flag. While the bus is frozen the host reads the code and decides the next step. It may move another byte, re-start the bus to turn the direction around, or release the bus with a stop. For a read, the host selects with `ack_en`, at the time it issues the command, whether that byte is acknowledged. The bit rate comes from a divider and a four-step prescaler.

Top module: `i2c_evt_master`

## Requirements
- R1: After reset both output enables are low, `flag` is low, and `status` reads `{5'd31, 1'b0, presc_sel}`, which is 0xF8 when masked with 0xF8.
- R2: Command encoding is `cmd` 1 = start, 2 = stop, 3 = byte, and a command is taken on a cycle where `cmd_valid` is high. In idle only start is taken, and a byte command there leaves both lines released and `flag` low. A start from idle pulls SDA low while SCL is high and then pulls SCL low. It ends with status code 0x08.
- R3: Every SCL high phase inside a byte lasts 8 + divider × P clock cycles, where P is 1, 4, 16 or 64 for `presc_sel` 0 to 3. This gives an SCL period of 16 + 2 × divider × P cycles.
- R4: Bytes are shifted out MSB first, and SDA changes only while SCL is low. If the address byte has bit 0 = 0, the next bytes are writes. Its code is 0x18 when the slave pulls SDA low in the ninth slot and 0x20 when the slave leaves SDA high.
- R5: A written data byte ends with code 0x28 if the slave acknowledged it and 0x30 if it did not.
- R6: If the address byte has bit 0 = 1, the next bytes are reads. Its code is 0x40 when acknowledged and 0x48 when not.
- R7: A read byte is sampled MSB first and presented on `rd_data`. With `ack_en` = 1 the master pulls SDA low in the ninth slot and the code is 0x50. With `ack_en` = 0 it leaves SDA high and the code is 0x58.
- R8: `flag` stays high until a command is taken. While it is high after any event except a lost bus, SCL is held low and neither line changes.
- R9: A start command while the bus is held gives a repeated start. The master releases SDA with SCL low, releases SCL, and then pulls SDA low while SCL is high. No stop appears on the bus, the code is 0x10, and the next byte is treated as an address.
- R10: A stop command pulls SDA low with SCL low, releases SCL, and then releases SDA while SCL is high. Both lines end released and `flag` stays low. The block returns to idle with `status` code 0xF8.
- R11: `status[2]` is always 0 and `status[1:0]` always equals `presc_sel`. Event codes therefore occupy only bits 7:3.
- R12: If the master releases SDA for a 1 bit of an address or written byte and samples it low, it releases both lines at once. It then sets `flag` with code 0x38, and the next start is a plain start.
- R13: While a slave holds SCL low after the master has released it, the bit does not advance. The high phase counts its full length from the moment SCL is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd | input | 2 | Host command: 1 start, 2 stop, 3 byte |
| wr_data | input | 8 | Address or data byte to send |
| ack_en | input | 1 | Acknowledge the byte read by this command |
| divider | input | DIV_W | Bit-rate divider |
| presc_sel | input | 2 | Prescaler select (x1, x4, x16, x64) |
| flag | output | 1 | Event pending, bus suspended |
| status | output | 8 | Event code in bits 7:3, prescaler select in bits 1:0 |
| rd_data | output | 8 | Last byte read from the bus |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The bench builds the block with the default 8-bit divider. It sweeps all four prescaler selects against divider values 0, 1 and 3, which makes the half period range from 8 to 200 cycles. Because the half periods stay short, each combination can run a whole transaction within the budget: write address, write data, repeated start, read address, an acknowledged read, a not-acknowledged read and a stop. A slave model on the open-drain wires supplies acknowledgements and read bytes. A bus monitor measures every SCL high phase and counts start and stop conditions. At the fastest setting the bench also forces address not-acknowledgements, holds SCL low from the slave side, and jams SDA low to provoke a lost bus.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    typedef enum logic [1:0] {
        HC_NOP   = 2'd0,
        HC_START = 2'd1,
        HC_STOP  = 2'd2,
        HC_XFER  = 2'd3
    } host_cmd_e;

    typedef enum logic [1:0] {OP_START, OP_RSTART, OP_STOP, OP_BYTE} bus_op_e;
    typedef enum logic [1:0] {CS_IDLE, CS_RUN, CS_HOLD} ctl_st_e;
    typedef enum logic [1:0] {PH_ADDR, PH_TX, PH_RX} phase_e;
    typedef enum logic [2:0] {K_START, K_RSTART, K_STOP, K_ADDR, K_TX, K_RX} kind_e;

    // event codes, presented in status[7:3]
    localparam logic [4:0] SC_START   = 5'd1;
    localparam logic [4:0] SC_RSTART  = 5'd2;
    localparam logic [4:0] SC_AW_ACK  = 5'd3;
    localparam logic [4:0] SC_AW_NACK = 5'd4;
    localparam logic [4:0] SC_DW_ACK  = 5'd5;
    localparam logic [4:0] SC_DW_NACK = 5'd6;
    localparam logic [4:0] SC_ARB     = 5'd7;
    localparam logic [4:0] SC_AR_ACK  = 5'd8;
    localparam logic [4:0] SC_AR_NACK = 5'd9;
    localparam logic [4:0] SC_DR_ACK  = 5'd10;
    localparam logic [4:0] SC_DR_NACK = 5'd11;
    localparam logic [4:0] SC_NONE    = 5'd31;

    localparam int unsigned BYTE_LAST = 18;

    typedef struct packed {
        logic       busy;
        bus_op_e    op;
        logic [4:0] step;
        logic [8:0] tx;
        logic [8:0] rx;
        logic       chk;
        logic       rest_scl;
        logic       rest_sda;
    } eng_t;

    typedef struct packed {
        ctl_st_e    st;
        phase_e     ph;
        logic       held;
        kind_e      kind;
        logic       dir_rd;
        logic       ack_q;
        logic [4:0] code;
        logic [7:0] rd;
    } ctl_t;

endpackage

// File: rtl/i2c_evt_rate.sv
module i2c_evt_rate #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divider,
    input  logic [1:0]       presc_sel,
    output logic             tick
);
    localparam int unsigned HW = DIV_W + 7;

    logic [HW-1:0] prod;
    logic [HW-1:0] half;
    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        prod  = HW'(divider) << {presc_sel, 1'b0};
        half  = HW'(8) + prod;
        tick  = !restart && (cnt_q == '0);
        if (restart || cnt_q == '0) begin
            cnt_d = half - HW'(1);
        end else begin
            cnt_d = cnt_q - HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2c_evt_bitio.sv
module i2c_evt_bitio
    import i2c_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       op_go,
    input  bus_op_e    op_kind,
    input  logic [8:0] tx_bits,
    input  logic       arb_chk,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       restart,
    output logic       done,
    output logic       lost,
    output logic [8:0] rx_bits,
    output logic       scl_lvl,
    output logic       sda_lvl
);
    eng_t q, n;

    logic       cur_scl, cur_sda, at_last, stalled;
    logic [3:0] idx;

    // line levels of the current half-period step
    always_comb begin
        idx     = q.step[4:1];
        cur_scl = 1'b1;
        cur_sda = 1'b1;
        at_last = 1'b0;
        case (q.op)
            OP_START: begin
                cur_scl = (q.step == 5'd0);
                cur_sda = 1'b0;
                at_last = (q.step == 5'd1);
            end
            OP_RSTART: begin
                cur_scl = (q.step == 5'd1) || (q.step == 5'd2);
                cur_sda = (q.step <= 5'd1);
                at_last = (q.step == 5'd3);
            end
            OP_STOP: begin
                cur_scl = (q.step != 5'd0);
                cur_sda = (q.step == 5'd2);
                at_last = (q.step == 5'd2);
            end
            default: begin
                if (q.step == 5'(BYTE_LAST)) begin
                    cur_scl = 1'b0;
                    cur_sda = 1'b1;
                    at_last = 1'b1;
                end else begin
                    cur_scl = q.step[0];
                    cur_sda = q.tx[4'd8 - idx];
                end
            end
        endcase
        stalled = cur_scl && !scl_in;
    end

    always_comb begin
        n       = q;
        done    = 1'b0;
        lost    = 1'b0;
        restart = 1'b0;
        if (!q.busy) begin
            if (op_go) begin
                n.busy  = 1'b1;
                n.op    = op_kind;
                n.step  = '0;
                n.tx    = tx_bits;
                n.chk   = arb_chk;
                n.rx    = '0;
                restart = 1'b1;
            end
        end else if (stalled) begin
            restart = 1'b1;
        end else if (tick) begin
            if (q.op == OP_BYTE && q.step[0]) begin
                n.rx = {q.rx[7:0], sda_in};
                if (q.chk && idx < 4'd8 && cur_sda && !sda_in) begin
                    lost = 1'b1;
                end
            end
            if (lost) begin
                n.busy     = 1'b0;
                n.rest_scl = 1'b1;
                n.rest_sda = 1'b1;
                done       = 1'b1;
            end else if (at_last) begin
                n.busy     = 1'b0;
                n.rest_scl = cur_scl;
                n.rest_sda = cur_sda;
                done       = 1'b1;
            end else begin
                n.step = q.step + 5'd1;
            end
        end
    end

    assign rx_bits = q.rx;
    assign scl_lvl = q.busy ? cur_scl : q.rest_scl;
    assign sda_lvl = q.busy ? cur_sda : q.rest_sda;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, op: OP_START, step: '0, tx: '0, rx: '0,
                   chk: 1'b0, rest_scl: 1'b1, rest_sda: 1'b1};
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
    import i2c_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic [7:0] wr_data,
    input  logic       ack_en,
    input  logic       eng_done,
    input  logic       eng_lost,
    input  logic [8:0] eng_rx,
    output logic       eng_go,
    output bus_op_e    eng_op,
    output logic [8:0] eng_tx,
    output logic       eng_chk,
    output logic       flag,
    output logic [4:0] code,
    output logic [7:0] rd_data
);
    ctl_t      q, n;
    host_cmd_e hc;
    logic      acked;

    always_comb begin
        n       = q;
        hc      = host_cmd_e'(cmd);
        acked   = !eng_rx[0];
        eng_go  = 1'b0;
        eng_op  = OP_START;
        eng_tx  = '0;
        eng_chk = 1'b0;
        case (q.st)
            CS_IDLE: begin
                if (cmd_valid && hc == HC_START) begin
                    eng_go = 1'b1;
                    eng_op = OP_START;
                    n.kind = K_START;
                    n.st   = CS_RUN;
                end
            end
            CS_HOLD: begin
                if (cmd_valid) begin
                    case (hc)
                        HC_START: begin
                            eng_go = 1'b1;
                            eng_op = q.held ? OP_RSTART : OP_START;
                            n.kind = q.held ? K_RSTART : K_START;
                            n.st   = CS_RUN;
                            n.code = SC_NONE;
                        end
                        HC_STOP: begin
                            n.code = SC_NONE;
                            if (q.held) begin
                                eng_go = 1'b1;
                                eng_op = OP_STOP;
                                n.kind = K_STOP;
                                n.st   = CS_RUN;
                            end else begin
                                n.st = CS_IDLE;
                            end
                        end
                        HC_XFER: begin
                            if (q.held) begin
                                eng_go = 1'b1;
                                eng_op = OP_BYTE;
                                n.st   = CS_RUN;
                                n.code = SC_NONE;
                                case (q.ph)
                                    PH_ADDR: begin
                                        eng_tx   = {wr_data, 1'b1};
                                        eng_chk  = 1'b1;
                                        n.kind   = K_ADDR;
                                        n.dir_rd = wr_data[0];
                                    end
                                    PH_TX: begin
                                        eng_tx  = {wr_data, 1'b1};
                                        eng_chk = 1'b1;
                                        n.kind  = K_TX;
                                    end
                                    default: begin
                                        eng_tx  = {8'hFF, !ack_en};
                                        n.kind  = K_RX;
                                        n.ack_q = ack_en;
                                    end
                                endcase
                            end
                        end
                        default: ;
                    endcase
                end
            end
            CS_RUN: begin
                if (eng_done) begin
                    n.st = CS_HOLD;
                    if (eng_lost) begin
                        n.code = SC_ARB;
                        n.held = 1'b0;
                    end else begin
                        case (q.kind)
                            K_START, K_RSTART: begin
                                n.code = (q.kind == K_START) ? SC_START : SC_RSTART;
                                n.held = 1'b1;
                                n.ph   = PH_ADDR;
                            end
                            K_STOP: begin
                                n.st   = CS_IDLE;
                                n.held = 1'b0;
                                n.code = SC_NONE;
                            end
                            K_ADDR: begin
                                if (q.dir_rd) begin
                                    n.code = acked ? SC_AR_ACK : SC_AR_NACK;
                                    n.ph   = PH_RX;
                                end else begin
                                    n.code = acked ? SC_AW_ACK : SC_AW_NACK;
                                    n.ph   = PH_TX;
                                end
                            end
                            K_TX: n.code = acked ? SC_DW_ACK : SC_DW_NACK;
                            default: begin
                                n.rd   = eng_rx[8:1];
                                n.code = q.ack_q ? SC_DR_ACK : SC_DR_NACK;
                            end
                        endcase
                    end
                end
            end
            default: n.st = CS_IDLE;
        endcase
    end

    assign flag    = (q.st == CS_HOLD);
    assign code    = q.code;
    assign rd_data = q.rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CS_IDLE, ph: PH_ADDR, held: 1'b0, kind: K_START,
                   dir_rd: 1'b0, ack_q: 1'b0, code: SC_NONE, rd: '0};
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/i2c_evt_master.sv
module i2c_evt_master
    import i2c_evt_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd,
    input  logic [7:0]       wr_data,
    input  logic             ack_en,
    input  logic [DIV_W-1:0] divider,
    input  logic [1:0]       presc_sel,
    output logic             flag,
    output logic [7:0]       status,
    output logic [7:0]       rd_data,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic       tick, restart, done, lost, go, chk, scl_lvl, sda_lvl;
    logic [8:0] rx_bits, tx_bits;
    logic [4:0] code;
    bus_op_e    op;

    i2c_evt_rate #(.DIV_W(DIV_W)) rate_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .divider(divider), .presc_sel(presc_sel), .tick(tick)
    );

    i2c_evt_bitio bitio_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .op_go(go), .op_kind(op),
        .tx_bits(tx_bits), .arb_chk(chk), .scl_in(scl_in), .sda_in(sda_in),
        .restart(restart), .done(done), .lost(lost), .rx_bits(rx_bits),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
    );

    i2c_evt_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_data(wr_data), .ack_en(ack_en), .eng_done(done), .eng_lost(lost),
        .eng_rx(rx_bits), .eng_go(go), .eng_op(op), .eng_tx(tx_bits),
        .eng_chk(chk), .flag(flag), .code(code), .rd_data(rd_data)
    );

    assign status = {code, 1'b0, presc_sel};
    assign scl_oe = !scl_lvl;
    assign sda_oe = !sda_lvl;
endmodule

// File: rtl/i2c_evt_master_chk.sv
module i2c_evt_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       flag,
    input logic [7:0] status,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R8: a raised flag is only cleared by a host command
    a_r8_flag_waits: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !cmd_valid |=> flag);

    // R8: SCL pulled low while suspended, unless the bus was lost
    a_r8_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
        flag && status[7:3] != 5'd7 |-> scl_oe);

    // R8: lines frozen while suspended
    a_r8_lines_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        flag && $past(flag) |-> $stable(scl_oe) && $stable(sda_oe));

    // R1: an event is always reported with a real code
    a_r1_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> status[7:3] != 5'd31);

    // R12: a lost bus leaves both lines released
    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        flag && status[7:3] == 5'd7 |-> !scl_oe && !sda_oe);

    // R10: leaving the suspended state without a new flag releases nothing early
    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> status[7:3] == 5'd31);
endmodule

bind i2c_evt_master i2c_evt_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .flag(flag),
    .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_evt_master_tb_top.sv
`timescale 1ns/1ps
module i2c_evt_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ack_en = 1'b0;
    logic [7:0] divider = 8'd0;
    logic [1:0] presc_sel = 2'd0;
    logic       flag, scl_oe, sda_oe, scl_in, sda_in;
    logic [7:0] status, rd_data;

    // slave model controls
    logic       s_txm = 1'b0, s_ack = 1'b1, s_hold = 1'b0, s_jam = 1'b0;
    logic [7:0] s_byte = 8'hFF;
    logic       s_drv;

    // monitor state
    logic       p_scl = 1'b1, p_sda = 1'b1, pend = 1'b0;
    logic [3:0] slot = 4'd0;
    logic [8:0] mon_sh = '0;
    logic [7:0] last_byte = '0;
    logic       last_ack = 1'b1;
    int         start_cnt = 0, stop_cnt = 0, hi_cnt = 0, fmin = 0, fmax = 0;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    assign s_drv  = s_txm ? (slot < 4'd8 && !s_byte[3'(4'd7 - slot)])
                          : (slot == 4'd8 && s_ack);
    assign scl_in = !scl_oe && !s_hold;
    assign sda_in = !sda_oe && !s_drv && !s_jam;

    i2c_evt_master dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_data(wr_data), .ack_en(ack_en), .divider(divider),
        .presc_sel(presc_sel), .flag(flag), .status(status),
        .rd_data(rd_data), .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_in && p_scl && sda_in != p_sda) begin
                if (!sda_in) begin
                    start_cnt <= start_cnt + 1;
                    slot <= 4'd0;
                    pend <= 1'b0;
                end else begin
                    stop_cnt <= stop_cnt + 1;
                end
            end else if (scl_in && !p_scl) begin
                hi_cnt <= 1;
                pend   <= 1'b1;
                mon_sh <= {mon_sh[7:0], sda_in};
                if (slot == 4'd0) begin
                    fmin <= 100000;
                    fmax <= 0;
                end
                if (slot == 4'd8) begin
                    last_byte <= mon_sh[7:0];
                    last_ack  <= sda_in;
                end
            end else if (scl_in && p_scl) begin
                hi_cnt <= hi_cnt + 1;
            end else if (!scl_in && p_scl) begin
                if (hi_cnt < fmin) fmin <= hi_cnt;
                if (hi_cnt > fmax) fmax <= hi_cnt;
                if (pend) begin
                    slot <= (slot == 4'd8) ? 4'd0 : slot + 4'd1;
                    pend <= 1'b0;
                end
            end
            p_scl <= scl_in;
            p_sda <= sda_in;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic [7:0] d, input logic a);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd = c; wr_data = d; ack_en = a;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd = 2'd0;
    endtask

    task automatic wait_flag(input string req);
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (flag) return;
        end
        chk({req, " flag timeout"}, 0, 1);
    endtask

    function automatic int half_of(input int dv, input int sel);
        return 8 + dv * (1 << (2 * sel));
    endfunction

    function automatic logic [7:0] st_exp(input int code, input int sel);
        return 8'((code << 3) | sel);
    endfunction

    task automatic do_stop(input int h);
        int st0;
        st0 = stop_cnt;
        s_txm = 1'b0;
        issue(2'd2, 8'h00, 1'b0);
        repeat (4 * h + 20) @(negedge clk);
        chk("R10 flag stays low", flag, 0);
        chk("R10 lines released", {scl_oe, sda_oe}, 0);
        chk("R10 stop seen", stop_cnt, st0 + 1);
        chk("R10 idle code", status, st_exp(31, presc_sel));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk("watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int st0, sp0, h, combo;
        logic [7:0] aw, ar, dat, rb1, rb2;
        repeat (4) @(negedge clk);
        chk("R1 oe after reset", {scl_oe, sda_oe}, 0);
        chk("R1 flag after reset", flag, 0);
        chk("R1 status after reset", status, 8'hF8);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                combo = s * 3 + k;
                divider = 8'((k == 2) ? 3 : k);
                presc_sel = 2'(s);
                h = half_of(int'(divider), s);
                aw  = {3'b101, 4'(combo), 1'b0};
                ar  = aw | 8'h01;
                dat = 8'(combo * 37 + 5);
                rb1 = ~dat;
                rb2 = dat ^ 8'h5A;
                s_txm = 1'b0; s_ack = 1'b1;
                repeat (5) @(negedge clk);
                chk("R11 low bits", status[2:0], {1'b0, 2'(s)});

                st0 = start_cnt;
                issue(2'd1, 8'h00, 1'b0);
                wait_flag("R2");
                chk("R2 start code", status, st_exp(1, s));
                chk("R2 start seen", start_cnt, st0 + 1);
                chk("R8 scl held", scl_oe, 1);

                issue(2'd3, aw, 1'b0);
                wait_flag("R4");
                chk("R4 addr write ack", status, st_exp(3, s));
                chk("R4 addr on bus", last_byte, aw);
                chk("R3 high min", fmin, h);
                chk("R3 high max", fmax, h);

                s_ack = combo[0];
                issue(2'd3, dat, 1'b0);
                wait_flag("R5");
                chk("R5 data write code", status, st_exp(combo[0] ? 5 : 6, s));
                chk("R5 data on bus", last_byte, dat);
                repeat (20) @(negedge clk);
                chk("R8 frozen after flag", {flag, scl_oe}, 2'b11);

                s_ack = 1'b1;
                st0 = start_cnt; sp0 = stop_cnt;
                issue(2'd1, 8'h00, 1'b0);
                wait_flag("R9");
                chk("R9 rstart code", status, st_exp(2, s));
                chk("R9 start count", start_cnt, st0 + 1);
                chk("R9 no stop", stop_cnt, sp0);

                issue(2'd3, ar, 1'b0);
                wait_flag("R6");
                chk("R6 addr read ack", status, st_exp(8, s));
                chk("R6 addr on bus", last_byte, ar);

                s_txm = 1'b1; s_byte = rb1;
                issue(2'd3, 8'h00, 1'b1);
                wait_flag("R7");
                chk("R7 read ack code", status, st_exp(10, s));
                chk("R7 read data", rd_data, rb1);
                chk("R7 master ack low", last_ack, 0);

                s_byte = rb2;
                issue(2'd3, 8'h00, 1'b0);
                wait_flag("R7");
                chk("R7 read nack code", status, st_exp(11, s));
                chk("R7 read data 2", rd_data, rb2);
                chk("R7 master nack high", last_ack, 1);

                do_stop(h);
            end
        end

        // fastest rate for the corner cases
        divider = 8'd0; presc_sel = 2'd0; h = 8;
        s_txm = 1'b0;

        issue(2'd3, 8'h55, 1'b0);
        repeat (100) @(negedge clk);
        chk("R2 byte ignored in idle flag", flag, 0);
        chk("R2 byte ignored in idle lines", {scl_oe, sda_oe}, 0);

        issue(2'd1, 8'h00, 1'b0);
        wait_flag("R4");
        s_ack = 1'b0;
        issue(2'd3, 8'h3C, 1'b0);
        wait_flag("R4");
        chk("R4 addr write nack", status, st_exp(4, 0));
        s_ack = 1'b1;
        issue(2'd1, 8'h00, 1'b0);
        wait_flag("R9");
        s_ack = 1'b0;
        issue(2'd3, 8'h3D, 1'b0);
        wait_flag("R6");
        chk("R6 addr read nack", status, st_exp(9, 0));
        s_ack = 1'b1;
        do_stop(h);

        // slave holds SCL low
        issue(2'd1, 8'h00, 1'b0);
        wait_flag("R13");
        issue(2'd3, 8'h44, 1'b0);
        wait_flag("R13");
        s_hold = 1'b1;
        issue(2'd3, 8'hC3, 1'b0);
        repeat (300) @(negedge clk);
        chk("R13 waits on held scl", {flag, scl_in}, 0);
        @(posedge clk); #1 s_hold = 1'b0;
        wait_flag("R13");
        chk("R13 code after stretch", status, st_exp(5, 0));
        chk("R13 byte after stretch", last_byte, 8'hC3);
        chk("R13 high phase length", fmin, h);
        do_stop(h);

        // lost bus
        issue(2'd1, 8'h00, 1'b0);
        wait_flag("R12");
        s_jam = 1'b1;
        issue(2'd3, 8'hA0, 1'b0);
        wait_flag("R12");
        chk("R12 lost code", status, st_exp(7, 0));
        chk("R12 lines released", {scl_oe, sda_oe}, 0);
        s_jam = 1'b0;
        issue(2'd1, 8'h00, 1'b0);
        wait_flag("R12");
        chk("R12 plain start after loss", status, st_exp(1, 0));
        do_stop(h);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule